// File: doc/BRIEF.md
# Transmit Packet Framer

The framer turns a payload held in an internal 256-byte packet buffer into a serial outgoing frame. A host fills the buffer through a byte write port and programs two independent frame profiles. A one-cycle start pulse launches a frame using the profile picked by the selector input. The frame is a run of preamble bytes (0x55), then a 16- or 32-bit sync word, then the payload read from the buffer, then an optional 16-bit CRC computed over the payload.

Bits leave most significant first, one bit for each cycle in which the downstream consumer raises the bit strobe. A downstream modulator consumes the bits. Fixed-length frames take their byte count from the profile. Variable-length frames read the count from the first buffer byte, and that byte is sent as part of the payload. When the last bit has been consumed, the framer returns to idle and pulses a completion flag.

Top module: `tx_framer`

## Requirements
- R1: After reset, `busy`, `bit_valid` and `done` are low, even if `bit_en` is high.
- R2: A frame begins with `pre_len` copies of the byte 0x55. A `pre_len` of 0 gives no preamble.
- R3: The sync word follows the preamble. With `cfg_sync_long`=1 all 32 bits are sent, starting at bit 31. With `cfg_sync_long`=0 only bits 15:0 are sent, starting at bit 15.
- R4: In fixed mode (`cfg_var_len`=0) the payload is `cfg_fix_len` bytes taken from addresses 0 upward. A length of 0 gives no payload.
- R5: In variable mode (`cfg_var_len`=1) the byte at address 0 holds a count L. That byte is sent first, followed by the bytes at addresses 1..L, for L+1 payload bytes in all. L=255 sends the whole buffer.
- R6: With `cfg_crc_en`=1, a 16-bit CRC follows the payload, most significant bit first. The CRC uses polynomial 0x1021 with initial value 0xFFFF, no reflection and no final XOR, and covers every payload byte sent, including the length byte. For the bytes "123456789" the CRC is 0x29B1. With `cfg_crc_en`=0 no CRC is sent.
- R7: Every byte is sent most significant bit first. `bit_valid` equals `busy AND bit_en`. The presented bit advances only on cycles where `bit_valid` is high.
- R8: `done` is high for exactly one cycle: the cycle after the last bit was presented with `bit_valid`. `busy` is low in that same cycle.
- R9: Two profiles are stored, written by `cfg_we` at index `cfg_idx`. The profile named by `prof_sel` at the start pulse is used for the whole frame. Changes to `prof_sel`, and profile writes made during a frame, do not alter that frame.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: `busy` is high in the cycle after an accepted `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_we | input | 1 | Packet buffer write enable |
| mem_addr | input | 8 | Packet buffer write address |
| mem_wdata | input | 8 | Packet buffer write data |
| cfg_we | input | 1 | Profile write enable |
| cfg_idx | input | 1 | Profile to write |
| cfg_pre_len | input | 8 | Preamble length in bytes |
| cfg_sync_long | input | 1 | 1: 32-bit sync, 0: 16-bit sync |
| cfg_sync_word | input | 32 | Sync word value |
| cfg_var_len | input | 1 | 1: variable length, 0: fixed length |
| cfg_fix_len | input | 8 | Payload byte count in fixed mode |
| cfg_crc_en | input | 1 | Append CRC |
| prof_sel | input | 1 | Profile used by the next frame |
| start | input | 1 | Begin a frame |
| bit_en | input | 1 | Bit strobe from the consumer |
| bit_out | output | 1 | Current frame bit |
| bit_valid | output | 1 | Bit consumed this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
`busy` is due one cycle after an accepted start. Each frame bit is visible combinationally during the cycle whose strobe consumes it. `done` is due in the cycle after the final consumed bit and must drop one cycle later. The bench changes `bit_en` on the falling edge, waits a short delay, and then samples `bit_valid`, `bit_out`, `busy` and `done`. Each sample therefore shows the state that the next rising edge acts on. This timing lets the bench rebuild the bit stream exactly and check `done` on the first falling edge after the last bit.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          CRC_W       = 16;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [7:0]  PRE_PATTERN = 8'h55;

    typedef enum logic [1:0] {
        PH_PRE  = 2'd0,
        PH_SYNC = 2'd1,
        PH_PAY  = 2'd2,
        PH_CRC  = 2'd3
    } phase_t;

    typedef struct packed {
        logic [7:0]  pre_len;
        logic        sync_long;
        logic [31:0] sync_word;
        logic        var_len;
        logic [7:0]  fix_len;
        logic        crc_en;
    } frame_cfg_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return fb ? ({c[14:0], 1'b0} ^ CRC_POLY) : {c[14:0], 1'b0};
    endfunction

    // k counts sync bytes in send order
    function automatic logic [7:0] sync_byte(input logic [31:0] w, input logic lng,
                                             input logic [1:0] k);
        logic [1:0] pos;
        pos = lng ? (2'd3 - k) : (2'd1 - k);
        return w[8*int'(pos) +: 8];
    endfunction

endpackage

// File: rtl/tx_pkt_ram.sv
module tx_pkt_ram #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tx_profile_bank.sv
module tx_profile_bank
    import tx_framer_pkg::*;
#(
    parameter int NPROF = 2,
    localparam int SEL_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  frame_cfg_t       wr_cfg,
    input  logic [SEL_W-1:0] rd_idx,
    output frame_cfg_t       rd_cfg
);
    frame_cfg_t bank [NPROF];

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        always_ff @(posedge clk) begin
            if (rst)                                  bank[p] <= '0;
            else if (wr_en && wr_idx == SEL_W'(p))    bank[p] <= wr_cfg;
        end
    end

    assign rd_cfg = bank[rd_idx];
endmodule

// File: rtl/tx_crc16.sv
module tx_crc16
    import tx_framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_q,
    output logic [15:0] crc_nx
);
    assign crc_nx = en ? crc_step(crc_q, din) : crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_SEED;
        else            crc_q <= crc_nx;
    end

    // R6: a new frame always starts from the seed value
    p_seed_after_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> crc_q == CRC_SEED);
    // R6: register only moves while payload bits are consumed
    p_hold_outside_payload_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(crc_q));
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tx_framer_pkg::*;
#(
    parameter int AW    = 8,
    localparam int CNT_W = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          bit_en,
    input  frame_cfg_t    cfg_in,
    input  logic [7:0]    ram_q,
    output logic [AW-1:0] ram_addr,
    input  logic [15:0]   crc_q,
    input  logic [15:0]   crc_nx,
    output logic          crc_clr,
    output logic          crc_en,
    output logic          bit_out,
    output logic          bit_valid,
    output logic          busy,
    output logic          done
);
    phase_t           ph, nx_ph;
    logic [CNT_W-1:0] cnt, nx_cnt, pay_len;
    logic [2:0]       bitcnt;
    logic [7:0]       sh, nx_byte;
    logic             nx_end;
    logic [AW-1:0]    idx;

    logic [7:0]       act_pre;
    logic             act_long;
    logic [31:0]      act_sync;
    logic             act_var;
    logic             act_crc;

    logic             accept;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] sync_n;

    assign accept    = start && !busy;
    assign bit_valid = busy && bit_en;
    assign bit_out   = sh[7];
    assign ram_addr  = idx;
    assign crc_clr   = accept;
    assign crc_en    = bit_valid && (ph == PH_PAY);
    assign cnt_inc   = cnt + CNT_W'(1);
    assign sync_n    = act_long ? CNT_W'(4) : CNT_W'(2);

    // choose the byte that follows the one now finishing
    always_comb begin
        nx_ph   = ph;
        nx_cnt  = cnt_inc;
        nx_byte = '0;
        nx_end  = 1'b0;
        unique case (ph)
            PH_PRE: begin
                if (cnt_inc < CNT_W'(act_pre)) begin
                    nx_byte = PRE_PATTERN;
                end else begin
                    nx_ph   = PH_SYNC;
                    nx_cnt  = '0;
                    nx_byte = sync_byte(act_sync, act_long, 2'd0);
                end
            end
            PH_SYNC: begin
                if (cnt_inc < sync_n) begin
                    nx_byte = sync_byte(act_sync, act_long, cnt_inc[1:0]);
                end else if (pay_len != '0) begin
                    nx_ph   = PH_PAY;
                    nx_cnt  = '0;
                    nx_byte = ram_q;
                end else if (act_crc) begin
                    nx_ph   = PH_CRC;
                    nx_cnt  = '0;
                    nx_byte = crc_nx[15:8];
                end else begin
                    nx_end  = 1'b1;
                end
            end
            PH_PAY: begin
                if (cnt_inc < pay_len) begin
                    nx_byte = ram_q;
                end else if (act_crc) begin
                    nx_ph   = PH_CRC;
                    nx_cnt  = '0;
                    nx_byte = crc_nx[15:8];
                end else begin
                    nx_end  = 1'b1;
                end
            end
            PH_CRC: begin
                if (cnt == '0) nx_byte = crc_q[7:0];
                else           nx_end  = 1'b1;
            end
            default: nx_end = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            ph       <= PH_PRE;
            cnt      <= '0;
            bitcnt   <= '0;
            sh       <= '0;
            idx      <= '0;
            pay_len  <= '0;
            act_pre  <= '0;
            act_long <= 1'b0;
            act_sync <= '0;
            act_var  <= 1'b0;
            act_crc  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                act_pre  <= cfg_in.pre_len;
                act_long <= cfg_in.sync_long;
                act_sync <= cfg_in.sync_word;
                act_var  <= cfg_in.var_len;
                act_crc  <= cfg_in.crc_en;
                busy     <= 1'b1;
                cnt      <= '0;
                bitcnt   <= '0;
                idx      <= '0;
                pay_len  <= cfg_in.var_len ? CNT_W'(1) : CNT_W'(cfg_in.fix_len);
                if (cfg_in.pre_len != '0) begin
                    ph <= PH_PRE;
                    sh <= PRE_PATTERN;
                end else begin
                    ph <= PH_SYNC;
                    sh <= sync_byte(cfg_in.sync_word, cfg_in.sync_long, 2'd0);
                end
            end else if (bit_valid) begin
                if (bitcnt != 3'd7) begin
                    sh     <= {sh[6:0], 1'b0};
                    bitcnt <= bitcnt + 3'd1;
                end else begin
                    bitcnt <= '0;
                    if (nx_end) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        ph  <= nx_ph;
                        cnt <= nx_cnt;
                        sh  <= nx_byte;
                        if (nx_ph == PH_PAY) begin
                            idx <= idx + AW'(1);
                            if (ph != PH_PAY && act_var)
                                pay_len <= CNT_W'(ram_q) + CNT_W'(1);
                        end
                    end
                end
            end
        end
    end

    // R8: completion flag accompanies the return to idle
    p_done_on_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R8: completion flag lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: no strobe, no movement of the outgoing bit
    p_stall_without_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_en) |=> (busy && $stable(sh) && $stable(bitcnt)));
    // R9 / R10: captured profile stays frozen for the frame
    p_profile_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(act_sync) && $stable(act_pre) &&
                                   $stable(act_crc) && $stable(act_var)));
    // R11: accepted start raises busy
    p_busy_after_start_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import tx_framer_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    parameter int NPROF     = 2,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int SEL_W    = (NPROF > 1) ? $clog2(NPROF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_addr,
    input  logic [7:0]       mem_wdata,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_pre_len,
    input  logic             cfg_sync_long,
    input  logic [31:0]      cfg_sync_word,
    input  logic             cfg_var_len,
    input  logic [7:0]       cfg_fix_len,
    input  logic             cfg_crc_en,
    input  logic [SEL_W-1:0] prof_sel,
    input  logic             start,
    input  logic             bit_en,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             busy,
    output logic             done
);
    frame_cfg_t    wr_cfg, sel_cfg;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [15:0]   crc_q, crc_nx;
    logic          crc_clr, crc_en;

    always_comb begin
        wr_cfg.pre_len   = cfg_pre_len;
        wr_cfg.sync_long = cfg_sync_long;
        wr_cfg.sync_word = cfg_sync_word;
        wr_cfg.var_len   = cfg_var_len;
        wr_cfg.fix_len   = cfg_fix_len;
        wr_cfg.crc_en    = cfg_crc_en;
    end

    tx_pkt_ram #(.DEPTH(MEM_DEPTH)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    tx_profile_bank #(.NPROF(NPROF)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_cfg (wr_cfg),
        .rd_idx (prof_sel),
        .rd_cfg (sel_cfg)
    );

    tx_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (crc_clr),
        .en     (crc_en),
        .din    (bit_out),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    tx_frame_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .bit_en    (bit_en),
        .cfg_in    (sel_cfg),
        .ram_q     (rd_data),
        .ram_addr  (rd_addr),
        .crc_q     (crc_q),
        .crc_nx    (crc_nx),
        .crc_clr   (crc_clr),
        .crc_en    (crc_en),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .busy      (busy),
        .done      (done)
    );

    // R7: a consumed bit only exists inside a frame
    p_valid_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (busy && bit_en));
    // R1: idle immediately after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done));
endmodule

// File: tb/tx_framer_test.sv
`timescale 1ns/1ps
module tx_framer_test;
    localparam real CLK_NS = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_addr = '0, mem_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [7:0]  cfg_pre_len = '0;
    logic        cfg_sync_long = 1'b0;
    logic [31:0] cfg_sync_word = '0;
    logic        cfg_var_len = 1'b0;
    logic [7:0]  cfg_fix_len = '0;
    logic        cfg_crc_en = 1'b0;
    logic [0:0]  prof_sel = '0;
    logic        start = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_out, bit_valid, busy, done;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mm [256];
    logic [7:0]  m_pre [2];
    logic        m_long [2];
    logic [31:0] m_sync [2];
    logic        m_var [2];
    logic [7:0]  m_fix [2];
    logic        m_crc [2];

    logic exp_q [$];
    logic got_q [$];

    always #(CLK_NS/2) clk = ~clk;

    tx_framer uut (
        .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pre_len(cfg_pre_len),
        .cfg_sync_long(cfg_sync_long), .cfg_sync_word(cfg_sync_word),
        .cfg_var_len(cfg_var_len), .cfg_fix_len(cfg_fix_len), .cfg_crc_en(cfg_crc_en),
        .prof_sel(prof_sel), .start(start), .bit_en(bit_en),
        .bit_out(bit_out), .bit_valid(bit_valid), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    task automatic wr_mem(input int a, input logic [7:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = 8'(a); mem_wdata = d; mm[a] = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic set_cfg(input int i, input logic [7:0] pre, input logic lng,
                           input logic [31:0] sw, input logic vr, input logic [7:0] fx,
                           input logic cr);
        m_pre[i] = pre; m_long[i] = lng; m_sync[i] = sw;
        m_var[i] = vr; m_fix[i] = fx; m_crc[i] = cr;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'(i); cfg_pre_len = pre; cfg_sync_long = lng;
        cfg_sync_word = sw; cfg_var_len = vr; cfg_fix_len = fx; cfg_crc_en = cr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb;
            fb = r[15] ^ b[k];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic void push_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
    endfunction

    // expected stream from the requirements R2..R6
    function automatic void build_expected(input int s);
        int n;
        logic [15:0] c;
        exp_q.delete();
        for (int k = 0; k < int'(m_pre[s]); k++) push_byte(8'h55);
        if (m_long[s]) begin
            push_byte(m_sync[s][31:24]); push_byte(m_sync[s][23:16]);
        end
        push_byte(m_sync[s][15:8]); push_byte(m_sync[s][7:0]);
        n = m_var[s] ? int'(mm[0]) + 1 : int'(m_fix[s]);
        c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            push_byte(mm[k]);
            c = crc_byte(c, mm[k]);
        end
        if (m_crc[s]) begin
            push_byte(c[15:8]); push_byte(c[7:0]);
        end
    endfunction

    // run one frame; mode 1 strobes one cycle in three; disturb pokes start, select and profile
    task automatic run_frame(input int s, input int mode, input bit disturb, input string tag);
        int cyc;
        int bad_strobe;
        bit found;
        int mis;
        build_expected(s);
        got_q.delete();
        @(negedge clk);
        prof_sel = 1'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy === 1'b1, "R11", longint'(busy), 1, "busy after start");
        cyc = 0; bad_strobe = 0;
        while (got_q.size() < exp_q.size() && cyc < 30000) begin
            if (cyc != 0) @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
            bit_en = (mode == 0) ? 1'b1 : ((cyc % 3) == 0);
            if (disturb && cyc == 25) begin
                start = 1'b1; prof_sel = 1'(~s);
                cfg_we = 1'b1; cfg_idx = 1'(s); cfg_pre_len = 8'd9; cfg_sync_long = ~m_long[s];
                cfg_sync_word = ~m_sync[s]; cfg_var_len = ~m_var[s]; cfg_fix_len = 8'd1;
                cfg_crc_en = ~m_crc[s];
            end
            #1;
            if (bit_valid && !bit_en) bad_strobe++;
            if (bit_valid) got_q.push_back(bit_out);
            if (!busy) cyc = 30000;
            cyc++;
        end
        @(negedge clk);
        bit_en = 1'b0; start = 1'b0; cfg_we = 1'b0;
        #1;
        chk(done === 1'b1 && busy === 1'b0, "R8", {done, busy}, 2'b10, {tag, " done after last bit"});
        @(negedge clk);
        #1;
        chk(done === 1'b0, "R8", longint'(done), 0, {tag, " done one cycle"});
        chk(bad_strobe == 0, "R7", bad_strobe, 0, {tag, " bit_valid without strobe"});
        chk(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size(), "frame bit count");
        found = 0; mis = 0;
        for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
            if (!found && got_q[k] !== exp_q[k]) begin found = 1; mis = k; end
        if (found)
            chk(0, tag, got_q[mis], exp_q[mis], $sformatf("bit %0d", mis));
        else
            chk(1, tag, 0, 0, "frame bits");
    endtask

    initial begin
        bit_en = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(busy === 1'b0 && done === 1'b0 && bit_valid === 1'b0, "R1",
            {busy, done, bit_valid}, 0, "reset state");
        @(negedge clk);
        rst = 1'b0; bit_en = 1'b0;
        #1;
        chk(busy === 1'b0 && bit_valid === 1'b0, "R1", {busy, bit_valid}, 0, "idle after reset");

        for (int a = 0; a < 256; a++) wr_mem(a, 8'((a * 37 + 11) & 255));

        // sweep: preamble length, sync width, CRC on/off, fixed/variable (R2 R3 R4 R5 R6)
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 2; l++)
                for (int c = 0; c < 2; c++)
                    for (int v = 0; v < 2; v++) begin
                        set_cfg(p % 2, 8'(p), 1'(l), 32'hA5C3_0F96 ^ 32'(p * 4099),
                                1'(v), 8'(5 + p), 1'(c));
                        run_frame(p % 2, p % 2, 0,
                                  $sformatf("R2 R3 %s R6 pre%0d long%0d crc%0d", v ? "R5" : "R4",
                                            p, l, c));
                    end

        // R6: known CRC vector over "123456789"
        for (int a = 0; a < 9; a++) wr_mem(a, 8'(8'h31 + a));
        set_cfg(0, 8'd0, 1'b0, 32'h0000_2DD4, 1'b0, 8'd9, 1'b1);
        run_frame(0, 0, 0, "R6 vector frame");
        begin
            logic [15:0] tail;
            tail = '0;
            for (int k = 0; k < 16; k++)
                if (got_q.size() >= 16) tail[15-k] = got_q[got_q.size() - 16 + k];
            chk(tail == 16'h29B1, "R6", tail, 16'h29B1, "check value");
        end

        // R4: zero-length fixed frame with CRC gives sync then 0xFFFF
        set_cfg(1, 8'd1, 1'b1, 32'h1234_5678, 1'b0, 8'd0, 1'b1);
        run_frame(1, 0, 0, "R4 R6 empty payload");

        // R5: maximum variable length covers the whole buffer
        wr_mem(0, 8'd255);
        set_cfg(0, 8'd2, 1'b0, 32'h0000_C33C, 1'b1, 8'd3, 1'b1);
        run_frame(0, 0, 0, "R5 full buffer");

        // R9 R10: mid-frame start, select flip and profile write have no effect
        wr_mem(0, 8'd6);
        set_cfg(0, 8'd3, 1'b0, 32'h0000_0F0F, 1'b0, 8'd2, 1'b0);
        set_cfg(1, 8'd2, 1'b1, 32'hDEAD_BEEF, 1'b1, 8'd4, 1'b1);
        run_frame(1, 0, 1, "R9 R10 disturbed frame");
        set_cfg(1, 8'd2, 1'b1, 32'hDEAD_BEEF, 1'b1, 8'd4, 1'b1);
        run_frame(0, 1, 0, "R9 other profile");

        summary();
    end
endmodule